// File: doc/BRIEF.md
# Memory-Type Ordering Write Buffer

This block sits between a processor-side request port and one downstream memory port. Every incoming access is classified by its address into one of three memory kinds: Normal, Device or Strongly-ordered. The address space is cut into seven fixed regions, and a parameter gives each region its kind. Writes to Normal and Device memory are posted. They enter a small write FIFO and are acknowledged at once. Writes to Strongly-ordered memory bypass the FIFO and are acknowledged only after the downstream port has finished them.

Loads are held back only as far as ordering requires. A Strongly-ordered access of either direction waits until the FIFO is completely empty. A Device read waits until no Device write is left in the FIFO. A Normal read that hits a buffered word is answered from the youngest matching entry and never reaches memory. A Normal read that misses may overtake buffered writes. Only one non-posted access is outstanding at a time, and the block accepts no new request while that access is in progress.

Top module: `ordwb_top`

## Requirements
- R1: Addresses are classified by regions starting at 0x00000000, 0x20000000, 0x40000000, 0x60000000, 0xA0000000, 0xE0000000 and 0xE0100000 (region indices 0 to 6). The default kinds are Normal for regions 0, 1 and 3, Device for regions 2, 4 and 6, and Strongly-ordered for region 5.
- R2: An accepted Normal or Device write is acknowledged by `rsp_valid` in the cycle after acceptance, with `rsp_rdata` zero, independent of the downstream port.
- R3: The write FIFO holds 4 entries; while it is full, `req_ready` is low for a posted write.
- R4: Buffered writes reach the downstream port in acceptance order, with unchanged address and data.
- R5: A Strongly-ordered write is never buffered. It is issued downstream only when the FIFO is empty, and it is acknowledged in the cycle after `mem_done`.
- R6: A Strongly-ordered read is issued downstream only when the FIFO is empty, and it returns `mem_rdata`.
- R7: A Device read is issued downstream only when no Device write remains buffered.
- R8: A Normal read whose word address (bits 31:2) matches a buffered write returns the youngest matching data in the cycle after acceptance, without a downstream access.
- R9: A Normal read that misses the FIFO is issued downstream, and its response carries `mem_rdata` in the cycle after `mem_done`.
- R10: While a non-posted access is outstanding, `req_ready` stays low.
- R11: After reset, `rsp_valid` and `mem_valid` are low and `req_ready` is high.
- R12: Once `mem_valid` is raised, it stays high with `mem_addr`, `mem_write` and `mem_wdata` unchanged until `mem_ready` is sampled high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_rdata | output | DATA_W | Read data, zero for write acknowledges |
| mem_valid | output | 1 | Downstream request present |
| mem_ready | input | 1 | Downstream accepts the request |
| mem_write | output | 1 | Downstream direction |
| mem_addr | output | 32 | Downstream address |
| mem_wdata | output | DATA_W | Downstream write data |
| mem_done | input | 1 | Downstream access complete |
| mem_rdata | input | DATA_W | Downstream read data, valid with mem_done |

## Verification
Posted writes and forwarded reads must produce their response one cycle after the accepting edge. The bench drives each request on a falling edge and checks `rsp_valid` at the very next falling edge. A non-posted access needs one edge to launch, one handshake edge and one completion edge before its registered response, so its response can appear no earlier than the fourth falling edge after acceptance. The bench counts falling edges and requires at least four. Ordering rules are checked at the moment each downstream handshake is committed. The bench model of the downstream port compares the handshake against its own queue of posted writes, which it built from the requirement-level address classification.

// File: rtl/ordwb_pkg.sv
package ordwb_pkg;

  localparam int ADDR_W   = 32;
  localparam int N_BOUND  = 6;
  localparam int N_REGION = N_BOUND + 1;

  typedef enum logic [1:0] {
    MT_NORMAL = 2'd0,
    MT_DEVICE = 2'd1,
    MT_STRONG = 2'd2
  } mem_kind_e;

  typedef enum logic [1:0] {
    MP_IDLE = 2'd0,
    MP_REQ  = 2'd1,
    MP_RESP = 2'd2
  } mport_state_e;

  // region index r occupies bits [2r+1:2r]
  localparam logic [2*N_REGION-1:0] DEFAULT_KINDS = {
    MT_DEVICE,  // 6 vendor space
    MT_STRONG,  // 5 private peripheral window
    MT_DEVICE,  // 4 external device
    MT_NORMAL,  // 3 external RAM
    MT_DEVICE,  // 2 peripheral
    MT_NORMAL,  // 1 SRAM
    MT_NORMAL   // 0 code
  };

  function automatic logic [ADDR_W-1:0] bound_at(input int idx);
    case (idx)
      0:       bound_at = 32'h2000_0000;
      1:       bound_at = 32'h4000_0000;
      2:       bound_at = 32'h6000_0000;
      3:       bound_at = 32'hA000_0000;
      4:       bound_at = 32'hE000_0000;
      5:       bound_at = 32'hE010_0000;
      default: bound_at = 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic same_word(input logic [ADDR_W-1:0] a,
                                     input logic [ADDR_W-1:0] b);
    same_word = (a[ADDR_W-1:2] == b[ADDR_W-1:2]);
  endfunction

endpackage

// File: rtl/ordwb_classify.sv
module ordwb_classify
  import ordwb_pkg::*;
#(
  parameter logic [2*N_REGION-1:0] KINDS = DEFAULT_KINDS
) (
  input  logic [ADDR_W-1:0] addr,
  output mem_kind_e         kind
);

  logic [N_BOUND-1:0] above;
  logic [2:0]         ridx;

  for (genvar gi = 0; gi < N_BOUND; gi++) begin : g_bound
    assign above[gi] = (addr >= bound_at(gi));
  end

  always_comb begin
    ridx = '0;
    for (int i = 0; i < N_BOUND; i++) begin
      ridx = ridx + {2'b00, above[i]};
    end
  end

  assign kind = mem_kind_e'(KINDS[{ridx, 1'b0} +: 2]);

endmodule

// File: rtl/ordwb_wfifo.sv
module ordwb_wfifo
  import ordwb_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int DATA_W = 32,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = PW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic [DATA_W-1:0] push_data,
  input  logic              push_dev,
  input  logic              pop,
  output logic [ADDR_W-1:0] head_addr,
  output logic [DATA_W-1:0] head_data,
  input  logic [ADDR_W-1:0] probe_addr,
  output logic              probe_hit,
  output logic [DATA_W-1:0] probe_data,
  output logic [CW-1:0]     count,
  output logic [CW-1:0]     dev_count,
  output logic              full,
  output logic              empty
);

  logic [ADDR_W-1:0] s_addr [DEPTH];
  logic [DATA_W-1:0] s_data [DEPTH];
  logic [DEPTH-1:0]  s_dev;
  logic [PW-1:0]     rd_ptr, wr_ptr;

  logic [CW-1:0]     slot_age [DEPTH];
  logic [DEPTH-1:0]  slot_live, slot_hit, slot_devl;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    bump = (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    assign slot_age[s]  = ({1'b0, rd_ptr} > CW'(s))
                        ? (CW'(s) + CW'(DEPTH) - {1'b0, rd_ptr})
                        : (CW'(s) - {1'b0, rd_ptr});
    assign slot_live[s] = (slot_age[s] < count);
    assign slot_hit[s]  = slot_live[s] && same_word(s_addr[s], probe_addr);
    assign slot_devl[s] = slot_live[s] && s_dev[s];
  end

  always_comb begin
    logic [CW-1:0] best;
    best       = '0;
    probe_hit  = 1'b0;
    probe_data = '0;
    for (int s = 0; s < DEPTH; s++) begin
      if (slot_hit[s] && (!probe_hit || slot_age[s] > best)) begin
        probe_hit  = 1'b1;
        best       = slot_age[s];
        probe_data = s_data[s];
      end
    end
  end

  always_comb begin
    dev_count = '0;
    for (int s = 0; s < DEPTH; s++) begin
      dev_count = dev_count + {{(CW-1){1'b0}}, slot_devl[s]};
    end
  end

  assign head_addr = s_addr[rd_ptr];
  assign head_data = s_data[rd_ptr];
  assign full      = (count == CW'(DEPTH));
  assign empty     = (count == '0);

  always_ff @(posedge clk) begin
    if (push) begin
      s_addr[wr_ptr] <= push_addr;
      s_data[wr_ptr] <= push_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
      s_dev  <= '0;
    end else begin
      if (push) begin
        wr_ptr         <= bump(wr_ptr);
        s_dev[wr_ptr]  <= push_dev;
      end
      if (pop) begin
        rd_ptr <= bump(rd_ptr);
      end
      count <= count + {{(CW-1){1'b0}}, push} - {{(CW-1){1'b0}}, pop};
    end
  end

endmodule

// File: rtl/ordwb_mport.sv
module ordwb_mport
  import ordwb_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic              l_write,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_data,
  output logic              idle,
  output logic              done_pulse,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_write,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_done
);

  mport_state_e state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= MP_IDLE;
      mem_write <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      unique case (state)
        MP_IDLE: if (launch) begin
          state     <= MP_REQ;
          mem_write <= l_write;
          mem_addr  <= l_addr;
          mem_wdata <= l_data;
        end
        MP_REQ:  if (mem_ready) state <= MP_RESP;
        MP_RESP: if (mem_done)  state <= MP_IDLE;
        default: state <= MP_IDLE;
      endcase
    end
  end

  assign mem_valid  = (state == MP_REQ);
  assign idle       = (state == MP_IDLE);
  assign done_pulse = (state == MP_RESP) && mem_done;

endmodule

// File: rtl/ordwb_top.sv
module ordwb_top
  import ordwb_pkg::*;
#(
  parameter int                    DATA_W       = 32,
  parameter int                    FIFO_DEPTH   = 4,
  parameter logic [2*N_REGION-1:0] REGION_KINDS = DEFAULT_KINDS,
  localparam int FPW = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1,
  localparam int FCW = FPW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [31:0]       req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_write,
  output logic [31:0]       mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_done,
  input  logic [DATA_W-1:0] mem_rdata
);

  mem_kind_e req_kind;

  ordwb_classify #(.KINDS(REGION_KINDS)) u_cls (
    .addr (req_addr),
    .kind (req_kind)
  );

  // named internal events
  logic              accept, posted_wr, fwd_read, push, pop;
  logic              fifo_full, fifo_empty, probe_hit;
  logic [FCW-1:0]    fifo_count, dev_count;
  logic [31:0]       head_addr;
  logic [DATA_W-1:0] head_data, probe_data;
  logic              op_gate_ok, dir_launch, drain_launch, mp_launch;
  logic              so_launch, dev_rd_launch;
  logic              mp_idle, done_pulse;

  // single outstanding non-posted access
  logic              op_busy, op_issued, op_write, owner_dir;
  logic [31:0]       op_addr;
  logic [DATA_W-1:0] op_data;
  mem_kind_e         op_kind;

  assign posted_wr = req_write && (req_kind != MT_STRONG);
  assign fwd_read  = !req_write && (req_kind == MT_NORMAL) && probe_hit;
  assign req_ready = !op_busy && !(posted_wr && fifo_full);
  assign accept    = req_valid && req_ready;
  assign push      = accept && posted_wr;

  ordwb_wfifo #(.DEPTH(FIFO_DEPTH), .DATA_W(DATA_W)) u_fifo (
    .clk        (clk),
    .rst_n      (rst_n),
    .push       (push),
    .push_addr  (req_addr),
    .push_data  (req_wdata),
    .push_dev   (req_kind == MT_DEVICE),
    .pop        (pop),
    .head_addr  (head_addr),
    .head_data  (head_data),
    .probe_addr (req_addr),
    .probe_hit  (probe_hit),
    .probe_data (probe_data),
    .count      (fifo_count),
    .dev_count  (dev_count),
    .full       (fifo_full),
    .empty      (fifo_empty)
  );

  always_comb begin
    unique case (op_kind)
      MT_STRONG: op_gate_ok = fifo_empty;
      MT_DEVICE: op_gate_ok = (dev_count == '0);
      default:   op_gate_ok = 1'b1;
    endcase
  end

  assign dir_launch    = op_busy && !op_issued && op_gate_ok && mp_idle;
  assign drain_launch  = mp_idle && !fifo_empty && !dir_launch;
  assign mp_launch     = dir_launch || drain_launch;
  assign so_launch     = dir_launch && (op_kind == MT_STRONG);
  assign dev_rd_launch = dir_launch && (op_kind == MT_DEVICE) && !op_write;
  assign pop           = done_pulse && !owner_dir;

  ordwb_mport #(.DATA_W(DATA_W)) u_mport (
    .clk        (clk),
    .rst_n      (rst_n),
    .launch     (mp_launch),
    .l_write    (dir_launch ? op_write : 1'b1),
    .l_addr     (dir_launch ? op_addr  : head_addr),
    .l_data     (dir_launch ? op_data  : head_data),
    .idle       (mp_idle),
    .done_pulse (done_pulse),
    .mem_valid  (mem_valid),
    .mem_ready  (mem_ready),
    .mem_write  (mem_write),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_done   (mem_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_busy   <= 1'b0;
      op_issued <= 1'b0;
      op_write  <= 1'b0;
      op_addr   <= '0;
      op_data   <= '0;
      op_kind   <= MT_NORMAL;
      owner_dir <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (accept) begin
        if (posted_wr) begin
          rsp_valid <= 1'b1;
          rsp_rdata <= '0;
        end else if (fwd_read) begin
          rsp_valid <= 1'b1;
          rsp_rdata <= probe_data;
        end else begin
          op_busy   <= 1'b1;
          op_issued <= 1'b0;
          op_write  <= req_write;
          op_addr   <= req_addr;
          op_data   <= req_wdata;
          op_kind   <= req_kind;
        end
      end
      if (dir_launch) op_issued <= 1'b1;
      if (mp_launch)  owner_dir <= dir_launch;
      if (done_pulse && owner_dir) begin
        op_busy   <= 1'b0;
        rsp_valid <= 1'b1;
        rsp_rdata <= op_write ? '0 : mem_rdata;
      end
    end
  end

endmodule

// File: rtl/ordwb_chk.sv
module ordwb_chk #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4,
  parameter int CW     = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rsp_valid,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic              mem_write,
  input logic [31:0]       mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_done,
  input logic              push,
  input logic              so_launch,
  input logic              dev_rd_launch,
  input logic [CW-1:0]     fifo_count,
  input logic [CW-1:0]     dev_count,
  input logic              op_busy
);

  // R2
  posted_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> rsp_valid);

  // R3
  fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_count <= CW'(DEPTH));

  // R5
  so_drained_chk: assert property (@(posedge clk) disable iff (!rst_n)
    so_launch |-> (fifo_count == '0));

  // R7
  dev_rd_drained_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dev_rd_launch |-> (dev_count == '0));

  // R5
  late_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(op_busy) |-> (rsp_valid && $past(mem_done)));

  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=>
      (mem_valid && $stable(mem_addr) && $stable(mem_wdata) && $stable(mem_write)));

endmodule

bind ordwb_top ordwb_chk #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH), .CW(FCW)) i_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .rsp_valid     (rsp_valid),
  .mem_valid     (mem_valid),
  .mem_ready     (mem_ready),
  .mem_write     (mem_write),
  .mem_addr      (mem_addr),
  .mem_wdata     (mem_wdata),
  .mem_done      (mem_done),
  .push          (push),
  .so_launch     (so_launch),
  .dev_rd_launch (dev_rd_launch),
  .fifo_count    (fifo_count),
  .dev_count     (dev_count),
  .op_busy       (op_busy)
);

// File: tb/test_ordwb_top.sv
module test_ordwb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [31:0] rsp_rdata;
  logic        mem_valid, mem_write;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ready = 1'b0, mem_done = 1'b0;
  logic [31:0] mem_rdata = '0;

  int tests = 0, fails = 0;
  int ready_mode = 1;
  int cyc = 0;

  always #10 clk = ~clk;

  ordwb_top i_ordwb_top (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_done(mem_done), .mem_rdata(mem_rdata)
  );

  // 0 Normal, 1 Device, 2 Strongly-ordered, by the R1 region table
  function automatic int btype(input logic [31:0] a);
    if (a >= 32'hE010_0000)      return 1;
    else if (a >= 32'hE000_0000) return 2;
    else if (a >= 32'hA000_0000) return 1;
    else if (a >= 32'h6000_0000) return 0;
    else if (a >= 32'h4000_0000) return 1;
    else                         return 0;
  endfunction

  function automatic logic [31:0] fresh(input logic [31:0] a);
    return {a[15:0], ~a[31:16]};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // downstream model and ordering monitor
  logic [31:0] store [logic [31:0]];
  logic [31:0] q_addr [$];
  logic [31:0] q_data [$];
  bit          done_pend = 0;
  logic [31:0] pend_data = '0;
  bit          hold_pend = 0;
  logic [31:0] hold_addr = '0;

  always @(negedge clk) begin
    cyc++;
    if (done_pend) begin
      mem_done  = 1'b1;
      mem_rdata = pend_data;
      done_pend = 0;
    end else begin
      mem_done = 1'b0;
    end
    if (hold_pend)
      chk(mem_valid && mem_addr == hold_addr, "R12", "request held", mem_addr, hold_addr);
    mem_ready = (ready_mode == 2) ? cyc[0] : (ready_mode == 1);
    if (mem_valid && mem_ready) begin
      logic [31:0] w;
      w = {mem_addr[31:2], 2'b00};
      if (mem_write) begin
        if (btype(mem_addr) != 2) begin
          chk(q_addr.size() != 0, "R4", "drain with nothing posted", 32'(q_addr.size()), 1);
          if (q_addr.size() != 0) begin
            chk(mem_addr == q_addr[0], "R4", "drain address order", mem_addr, q_addr[0]);
            chk(mem_wdata == q_data[0], "R4", "drain data", mem_wdata, q_data[0]);
            void'(q_addr.pop_front());
            void'(q_data.pop_front());
          end
        end else begin
          chk(q_addr.size() == 0, "R5", "strong write issued before drain", 32'(q_addr.size()), 0);
        end
        store[w] = mem_wdata;
      end else begin
        if (btype(mem_addr) == 2)
          chk(q_addr.size() == 0, "R6", "strong read issued before drain", 32'(q_addr.size()), 0);
        if (btype(mem_addr) == 1) begin
          int nd;
          nd = 0;
          foreach (q_addr[k]) if (btype(q_addr[k]) == 1) nd++;
          chk(nd == 0, "R7", "device read passed device write", 32'(nd), 0);
        end
        pend_data = store.exists(w) ? store[w] : fresh(w);
      end
      done_pend = 1;
    end
    hold_pend = mem_valid && !mem_ready;
    hold_addr = mem_addr;
  end

  task automatic do_req(input bit we, input logic [31:0] a, input logic [31:0] d,
                        output logic [31:0] rd, output int lat);
    @(negedge clk);
    req_valid = 1'b1; req_write = we; req_addr = a; req_wdata = d;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    if (we && btype(a) != 2) begin
      q_addr.push_back(a);
      q_data.push_back(d);
    end
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    #1;
    while (!rsp_valid) begin @(negedge clk); #1; lat++; end
    rd = rsp_rdata;
  endtask

  task automatic wait_drain();
    ready_mode = 1;
    @(negedge clk);
    while (q_addr.size() != 0 || mem_valid || done_pend || mem_done) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int          lat;
    logic [31:0] bounds [6];
    bounds = '{32'h2000_0000, 32'h4000_0000, 32'h6000_0000,
               32'hA000_0000, 32'hE000_0000, 32'hE010_0000};

    repeat (3) @(negedge clk);
    #1;
    // R11
    chk(!rsp_valid, "R11", "rsp_valid in reset", 32'(rsp_valid), 0);
    chk(!mem_valid, "R11", "mem_valid in reset", 32'(mem_valid), 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(req_ready, "R11", "req_ready after reset", 32'(req_ready), 1);

    // R1 R2 R5: boundary sweep of writes, each side of every split
    ready_mode = 2;
    foreach (bounds[i]) begin
      for (int s = 0; s < 2; s++) begin
        logic [31:0] a;
        a = (s == 0) ? bounds[i] - 32'd4 : bounds[i];
        do_req(1'b1, a, a ^ 32'h0F0F_1234, rd, lat);
        if (btype(a) == 2)
          chk(lat >= 4, "R5", "strong write acked early", 32'(lat), 4);
        else begin
          chk(lat == 1, "R2", "posted write ack latency", 32'(lat), 1);
          chk(rd == 0, "R2", "posted ack data", rd, 0);
        end
      end
    end
    // R1 R8 R9: read back every swept address
    foreach (bounds[i]) begin
      for (int s = 0; s < 2; s++) begin
        logic [31:0] a;
        a = (s == 0) ? bounds[i] - 32'd4 : bounds[i];
        do_req(1'b0, a, 0, rd, lat);
        chk(rd == (a ^ 32'h0F0F_1234), "R1", "read back after classify", rd, a ^ 32'h0F0F_1234);
      end
    end

    // R3: fill the FIFO with the port stalled
    wait_drain();
    ready_mode = 0;
    for (int k = 0; k < 4; k++) begin
      do_req(1'b1, 32'h2000_0100 + 32'(4 * k), 32'h100 + 32'(k), rd, lat);
      chk(lat == 1, "R2", "posted while stalled", 32'(lat), 1);
    end
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 32'h4000_0200; req_wdata = 32'h55;
    for (int k = 0; k < 3; k++) begin
      #1;
      chk(!req_ready, "R3", "ready while full", 32'(req_ready), 0);
      @(negedge clk);
    end
    req_valid = 1'b0;
    ready_mode = 1;
    do_req(1'b1, 32'h4000_0200, 32'h55, rd, lat);
    wait_drain();
    do_req(1'b0, 32'h2000_010C, 0, rd, lat);
    chk(rd == 32'h103, "R4", "last drained value", rd, 32'h103);

    // R8 R9: forwarding of the youngest match, then a miss
    ready_mode = 0;
    do_req(1'b1, 32'h6000_0040, 32'd11, rd, lat);
    do_req(1'b1, 32'h6000_0080, 32'd22, rd, lat);
    do_req(1'b1, 32'h6000_0040, 32'd33, rd, lat);
    do_req(1'b0, 32'h6000_0040, 0, rd, lat);
    chk(lat == 1, "R8", "forward latency", 32'(lat), 1);
    chk(rd == 32'd33, "R8", "youngest forwarded", rd, 32'd33);
    do_req(1'b0, 32'h6000_0042, 0, rd, lat);
    chk(rd == 32'd33 && lat == 1, "R8", "same word other byte", rd, 32'd33);
    ready_mode = 1;
    do_req(1'b0, 32'h6000_0100, 0, rd, lat);
    chk(rd == fresh(32'h6000_0100), "R9", "miss data", rd, fresh(32'h6000_0100));
    chk(lat >= 4, "R9", "miss latency", 32'(lat), 4);
    wait_drain();
    do_req(1'b0, 32'h6000_0040, 0, rd, lat);
    chk(rd == 32'd33, "R4", "final value in memory", rd, 32'd33);

    // R7: device read behind device writes
    ready_mode = 0;
    do_req(1'b1, 32'h4000_0010, 32'hAAAA_0001, rd, lat);
    do_req(1'b1, 32'h4000_0014, 32'hAAAA_0002, rd, lat);
    ready_mode = 2;
    do_req(1'b0, 32'h4000_0014, 0, rd, lat);
    chk(rd == 32'hAAAA_0002, "R7", "device read sees write", rd, 32'hAAAA_0002);
    chk(lat >= 4, "R7", "device read latency", 32'(lat), 4);

    // R6: strong read behind normal writes
    wait_drain();
    ready_mode = 0;
    do_req(1'b1, 32'h2000_0300, 32'h3, rd, lat);
    do_req(1'b1, 32'hA000_0300, 32'h4, rd, lat);
    ready_mode = 2;
    do_req(1'b0, 32'hE000_0ED0, 0, rd, lat);
    chk(rd == fresh(32'hE000_0ED0), "R6", "strong read data", rd, fresh(32'hE000_0ED0));

    // R10: blocked while a strong write is outstanding
    wait_drain();
    ready_mode = 0;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 32'hE000_0010; req_wdata = 32'hC0DE;
    #1;
    chk(req_ready, "R10", "strong write accepted when idle", 32'(req_ready), 1);
    @(negedge clk);
    req_addr = 32'h2000_0400; req_wdata = 32'h77;
    for (int k = 0; k < 3; k++) begin
      #1;
      chk(!req_ready, "R10", "ready while outstanding", 32'(req_ready), 0);
      @(negedge clk);
    end
    ready_mode = 1;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    q_addr.push_back(32'h2000_0400);
    q_data.push_back(32'h77);
    @(negedge clk);
    req_valid = 1'b0;
    wait_drain();
    do_req(1'b0, 32'hE000_0010, 0, rd, lat);
    chk(rd == 32'hC0DE, "R5", "strong write landed", rd, 32'hC0DE);
    do_req(1'b0, 32'h2000_0400, 0, rd, lat);
    chk(rd == 32'h77, "R10", "held write completed", rd, 32'h77);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule